// File: doc/BRIEF.md
# Time-Code Event Snapshot Reporter

This block sits between a time-code receiver front end and a slow host link. It keeps track of two kinds of event: the start of each locally generated reference second, and the arrival of a newly decoded time-code symbol, which is a 4-bit code. When a query strobe arrives while the block is idle, it freezes an 8-byte status report. It then sends that report one byte per accepted ready/valid handshake.

The report holds three things. The first is a set of sticky flags. The second is the newest decoded symbol. The third is three 16-bit values taken in the query cycle: the count elapsed since the last reference second, the current phase between the reference second and the received signal, and the current second length in counts. The host adds phase and elapsed count to place the query instant against the received signal. The sticky flags tell the host that a new second began, or that a symbol was overwritten, between two queries, so such events are not lost without notice.

Top module: `tcode_report_tx`

## Requirements
- R1: After a synchronous active-low reset, `out_valid_o` is 0, and the first report has flags byte 0x00 and symbol byte 0x00.
- R2: A report is eight bytes, sent in this order: flags, symbol, stamp, phase, interval. Each 16-bit field is sent low byte first, so stamp is in bytes 2–3, phase in bytes 4–5 and interval in bytes 6–7.
- R3: Flags bit 4 is 1 when at least one reference-second strobe has occurred since the previous report was frozen. Flags bits 7:5, 3 and 2 are always 0.
- R4: Flags bit 0 is 1 when a decoded symbol has arrived since the previous report was frozen. The symbol byte then carries that newest 4-bit code in bits 3:0 with bits 7:4 zero, using code 0 for a zero bit, 1 for a one bit, 8 for a sync marker and 15 for an invalid bit. When flags bit 0 is 0, the symbol byte is 0x00.
- R5: Flags bit 1 is 1 when a symbol arrived while an earlier symbol was still unreported. Only the newest symbol is kept.
- R6: The stamp, phase and interval fields carry the values of `count_i`, `phase_i` and `interval_i` in the cycle the query is accepted. Later changes to those inputs do not alter a report that is already frozen.
- R7: Freezing a report clears flags bits 4, 1 and 0. A second strobe or a symbol strobe in the freezing cycle, or while the report is being sent, belongs to the next report. A symbol strobe in the freezing cycle sets bit 0 of the next report and leaves its bit 1 at 0.
- R8: A query is accepted only while idle. The first byte is valid in the cycle after acceptance. While `out_valid_o` is 1 and `out_ready_i` is 0, the data and `out_last_o` hold steady. `out_last_o` is 1 only on byte 7. After byte 7 is accepted, `out_valid_o` is 0.
- R9: A query strobe that arrives while a report is being sent is ignored: the bytes still to come are unchanged, and no extra report follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_strobe_i | input | 1 | One-cycle pulse at each reference-second start |
| sym_strobe_i | input | 1 | One-cycle pulse with a newly decoded symbol |
| sym_code_i | input | 4 | Symbol code, valid with `sym_strobe_i` |
| count_i | input | 16 | Counts elapsed since the last reference second |
| phase_i | input | 16 | Current phase between reference second and received signal |
| interval_i | input | 16 | Current second length in counts |
| query_i | input | 1 | Report request strobe |
| out_valid_o | output | 1 | Report byte is valid |
| out_data_o | output | 8 | Report byte |
| out_last_o | output | 1 | Marks the final byte of a report |
| out_ready_i | input | 1 | Receiver accepts the byte |

## Verification
Wrong sticky-flag state shows up in the flags byte of the next report. If a set is missed, a clear is missed, or a freeze-cycle collision is resolved the wrong way, the error appears at most one report later. An error in the frozen stamp or in the byte order shows within the eight bytes of the report that is being sent. A handshake fault shows in the first stalled cycle, or as a missing or extra byte at the end of a report.

// File: rtl/tcode_report_pkg.sv
// Package: shared widths and the flags-byte bit positions for the report.
// Assumes: fixed 8-byte report format with 16-bit timing fields.
package tcode_report_pkg;
    localparam int SYM_W      = 4;
    localparam int FIELD_W    = 16;
    localparam int BYTE_W     = 8;
    localparam int N_BYTES    = 2 + 3 * (FIELD_W / BYTE_W);
    localparam int FRAME_W    = N_BYTES * BYTE_W;
    localparam int IDX_W      = $clog2(N_BYTES);
    localparam int FLG_NEWSEC = 4;
    localparam int FLG_LOST   = 1;
    localparam int FLG_VALID  = 0;
endpackage

// File: rtl/tcode_event_tracker.sv
// Module: sticky event state between reports.
// Keeps the newest symbol code, a pending-symbol flag, an overwritten flag
// and a new-second flag. take_i clears them, but an event in the same cycle wins.
// Assumes: strobes are single-cycle and synchronous to clk.
module tcode_event_tracker
    import tcode_report_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_i,
    input  logic             sym_i,
    input  logic [SYM_W-1:0] code_i,
    input  logic             take_i,
    output logic             new_sec_o,
    output logic             pend_o,
    output logic             lost_o,
    output logic [SYM_W-1:0] code_o
);
    logic             nsec_q, pend_q, lost_q;
    logic [SYM_W-1:0] code_q;

    // Update the sticky flags and the newest symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nsec_q <= 1'b0;
            pend_q <= 1'b0;
            lost_q <= 1'b0;
            code_q <= '0;
        end else begin
            if (sec_i)       nsec_q <= 1'b1;
            else if (take_i) nsec_q <= 1'b0;
            if (sym_i) begin
                code_q <= code_i;
                pend_q <= 1'b1;
                lost_q <= take_i ? 1'b0 : (lost_q | pend_q);
            end else if (take_i) begin
                pend_q <= 1'b0;
                lost_q <= 1'b0;
            end
        end
    end

    assign new_sec_o = nsec_q;
    assign pend_o    = pend_q;
    assign lost_o    = lost_q;
    assign code_o    = code_q;

    // R5: an overwrite can only be flagged while a symbol is pending.
    a_r5_lost_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q |-> pend_q);
    // R7: a freeze with no symbol strobe leaves nothing pending.
    a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !sym_i) |=> !pend_q && !lost_q);
    // R7: a freeze-cycle symbol goes to the next report without an overwrite.
    a_r7_collide_sym: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && sym_i) |=> pend_q && !lost_q);
endmodule

// File: rtl/tcode_byte_streamer.sv
// Module: holds a frozen frame and sends it byte 0 first over ready/valid.
// Assumes: load_i is only honoured while idle; the caller gates it with busy_o.
module tcode_byte_streamer
    import tcode_report_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic [BYTE_W-1:0]  data_o,
    output logic               last_o,
    output logic               busy_o
);
    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   idx_q;
    logic               act_q;
    logic [BYTE_W-1:0]  bytes [N_BYTES];

    // Split the frozen frame into an array of bytes.
    for (genvar b = 0; b < N_BYTES; b++) begin : g_split
        assign bytes[b] = frame_q[b*BYTE_W +: BYTE_W];
    end

    // Step through the bytes, one per accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            idx_q   <= '0;
            frame_q <= '0;
        end else if (!act_q) begin
            if (load_i) begin
                act_q   <= 1'b1;
                idx_q   <= '0;
                frame_q <= frame_i;
            end
        end else if (ready_i) begin
            if (idx_q == IDX_W'(N_BYTES - 1)) act_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign valid_o = act_q;
    assign busy_o  = act_q;
    assign data_o  = bytes[idx_q];
    assign last_o  = act_q && (idx_q == IDX_W'(N_BYTES - 1));

    // R8: a stalled byte holds steady.
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o && $stable(data_o) && $stable(last_o));
    // R8: nothing follows an accepted final byte.
    a_r8_end_of_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && ready_i) |=> !valid_o);
    // R8: an accepted query produces a valid first byte.
    a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |=> valid_o && !last_o);
    // R9: a query during streaming does not change the frozen frame.
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(frame_q));
endmodule

// File: rtl/tcode_report_tx.sv
// Module: top of the time-code snapshot reporter.
// Freezes the flags, the symbol and the timing inputs when a query arrives while idle,
// then sends the 8-byte report through the byte streamer.
// Assumes: count/phase/interval inputs are already synchronous to clk.
module tcode_report_tx
    import tcode_report_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_strobe_i,
    input  logic               sym_strobe_i,
    input  logic [SYM_W-1:0]   sym_code_i,
    input  logic [FIELD_W-1:0] count_i,
    input  logic [FIELD_W-1:0] phase_i,
    input  logic [FIELD_W-1:0] interval_i,
    input  logic               query_i,
    output logic               out_valid_o,
    output logic [BYTE_W-1:0]  out_data_o,
    output logic               out_last_o,
    input  logic               out_ready_i
);
    logic               busy, take, nsec, pend, lost;
    logic [SYM_W-1:0]   code;
    logic [BYTE_W-1:0]  flags_b, sym_b;
    logic [FRAME_W-1:0] frame;

    assign take = query_i && !busy;

    tcode_event_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .sec_i(sec_strobe_i), .sym_i(sym_strobe_i),
        .code_i(sym_code_i), .take_i(take), .new_sec_o(nsec), .pend_o(pend),
        .lost_o(lost), .code_o(code)
    );

    // Build the flags and symbol bytes from the tracker state.
    always_comb begin
        flags_b             = '0;
        flags_b[FLG_NEWSEC] = nsec;
        flags_b[FLG_LOST]   = lost;
        flags_b[FLG_VALID]  = pend;
        sym_b               = pend ? BYTE_W'(code) : '0;
    end

    // Lay out the frame with byte 0 in the low bits; fields go low byte first.
    assign frame = {interval_i, phase_i, count_i, sym_b, flags_b};

    tcode_byte_streamer u_str (
        .clk(clk), .rst_n(rst_n), .load_i(take), .frame_i(frame),
        .ready_i(out_ready_i), .valid_o(out_valid_o), .data_o(out_data_o),
        .last_o(out_last_o), .busy_o(busy)
    );

    // R4: no valid symbol means the symbol byte is zero.
    a_r4_sym_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> sym_b == '0);
endmodule

// File: tb/sim_tcode_report_tx.sv
module sim_tcode_report_tx;
    logic clk = 0, rst_n = 0;
    logic sec = 0, sym = 0, query = 0, ready = 0;
    logic [3:0]  code = 0;
    logic [15:0] cnt = 0, ph = 0, itv = 0;
    logic        ov, ol;
    logic [7:0]  od;
    int checks = 0, errors = 0;
    // bench model of the sticky state
    bit m_ns, m_pd, m_lt;
    logic [3:0] m_code;
    logic [7:0] exp_b [8];

    always #4 clk = ~clk;

    tcode_report_tx u0 (
        .clk(clk), .rst_n(rst_n), .sec_strobe_i(sec), .sym_strobe_i(sym),
        .sym_code_i(code), .count_i(cnt), .phase_i(ph), .interval_i(itv),
        .query_i(query), .out_valid_o(ov), .out_data_o(od), .out_last_o(ol),
        .out_ready_i(ready)
    );

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // model updates (at negedge, before the edge that applies them)
    task automatic ev_sec();
        sec = 1; m_ns = 1; @(negedge clk); sec = 0;
    endtask
    task automatic ev_sym(logic [3:0] c);
        sym = 1; code = c; m_lt = m_lt | m_pd; m_pd = 1; m_code = c;
        @(negedge clk); sym = 0;
    endtask

    // freeze a report now: computes expected bytes, then clears the model flags
    task automatic freeze(logic [15:0] c, logic [15:0] p, logic [15:0] i,
                          bit with_sec, bit with_sym, logic [3:0] sc);
        exp_b[0] = {3'b0, m_ns, 2'b0, m_lt, m_pd};
        exp_b[1] = m_pd ? {4'b0, m_code} : 8'h00;
        exp_b[2] = c[7:0]; exp_b[3] = c[15:8];
        exp_b[4] = p[7:0]; exp_b[5] = p[15:8];
        exp_b[6] = i[7:0]; exp_b[7] = i[15:8];
        m_ns = with_sec; m_lt = 0; m_pd = with_sym;
        if (with_sym) m_code = sc;
        cnt = c; ph = p; itv = i; query = 1;
        sec = with_sec; sym = with_sym; code = sc;
        @(negedge clk);
        query = 0; sec = 0; sym = 0;
        cnt = ~c; ph = ~p; itv = ~i;   // R6: later input changes must not leak
    endtask

    // receive 8 bytes; stall cycles before each; optional busy query / event at byte 3
    task automatic receive(int stall, bit busy_query, bit busy_sym, logic [3:0] bc);
        for (int b = 0; b < 8; b++) begin
            ready = 0;
            for (int s = 0; s < stall; s++) begin
                if (b == 3 && s == 0 && busy_query) query = 1;
                if (b == 3 && s == 0 && busy_sym) begin
                    sym = 1; code = bc; m_lt = m_lt | m_pd; m_pd = 1; m_code = bc;
                end
                @(negedge clk);
                query = 0; sym = 0;
                chk("R8 valid held", 16'(ov), 16'd1);
                chk("R8 data held", 16'(od), 16'(exp_b[b]));
            end
            chk("R8 valid", 16'(ov), 16'd1);
            chk($sformatf("R2 byte %0d", b), 16'(od), 16'(exp_b[b]));
            chk("R8 last", 16'(ol), 16'(b == 7));
            ready = 1;
            @(negedge clk);
        end
        ready = 0;
        chk("R8 R9 idle after report", 16'(ov), 16'd0);
        @(negedge clk);
        chk("R9 no extra report", 16'(ov), 16'd0);
    endtask

    initial begin
        logic [3:0] codes [4];
        codes[0] = 4'd0; codes[1] = 4'd1; codes[2] = 4'd8; codes[3] = 4'd15;
        m_ns = 0; m_pd = 0; m_lt = 0; m_code = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 16'(ov), 16'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", 16'(ov), 16'd0);
        // R1: first report with nothing happened
        freeze(16'h1234, 16'hA5C3, 16'hB71F, 0, 0, 0);
        receive(0, 0, 0, 0);
        // sweep: symbol count, second strobe, code; R3 R4 R5 R2 R6
        for (int n = 0; n < 3; n++)
            for (int s = 0; s < 2; s++)
                for (int k = 0; k < 4; k++) begin
                    if (s) ev_sec();
                    for (int j = 0; j < n; j++) ev_sym(codes[(k + j) % 4]);
                    @(negedge clk);
                    freeze(16'(n * 4099 + k * 257 + s), 16'(k * 7001 + 3),
                           16'(46875 + n + k), 0, 0, 0);
                    receive((n + k) % 3, 0, 0, 0);
                end
        // R7: events in the freeze cycle belong to the next report
        ev_sym(4'd1);
        freeze(16'h0F0F, 16'h0101, 16'hFFFF, 1, 1, 4'd8);
        receive(1, 0, 0, 0);
        freeze(16'h8000, 16'h0002, 16'h0003, 0, 0, 0);
        receive(0, 0, 0, 0);
        // R9 + R7: query and symbol during streaming
        freeze(16'h00FF, 16'hFF00, 16'h5555, 0, 0, 0);
        receive(2, 1, 1, 4'd15);
        freeze(16'h7777, 16'h1111, 16'h2222, 0, 0, 0);
        receive(1, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule